// File: doc/BRIEF.md
# Instruction-Count Debug Trigger Unit

This block holds a small bank of debug triggers that count retired instructions. Each trigger slot stores a type code, a set of privilege-mode enables and a 14-bit down-counter. A slot takes part in counting only when its type code names the instruction-count type and its counter is nonzero. Every retired instruction at a privilege level the slot's enables select lowers the counter by one. The retirement that takes the counter from one to zero raises a single fire pulse, which the core turns into a breakpoint exception. The slot then stays idle until it is configured again.

Configuration arrives as a write that loads the type, the mode enables and the count of one slot in a single cycle. When the core runs virtualised, the two virtual-mode enables decide whether a slot qualifies. Otherwise the user, supervisor and machine enables decide it. A status output tells the core whether any slot is currently counting in the present mode, so that the core can enable single-instruction stepping only when it is needed.

Top module: `icnt_trig_unit`

## Requirements
- R1: Only a slot whose stored type equals the instruction-count code (3) ever decrements or fires. A slot loaded with any other type is inert.
- R2: A slot whose count is zero neither decrements nor fires. After it fires, it stays idle and raises no further pulse until it is written again.
- R3: A cycle with `retire_i` high lowers the count of every qualifying slot by exactly one. A cycle with `retire_i` low changes no count.
- R4: `fire_o` is high for exactly one cycle, in the cycle after the clock edge at which a qualifying retirement takes a slot's count from 1 to 0.
- R5: When `virt_i` is low, a slot qualifies when its mode enable for the current privilege is set. The privilege encoding is 0 = user, 1 = supervisor, 3 = machine, and 2 never qualifies. The mode field is bit0 = user, bit1 = supervisor, bit2 = machine, bit3 = virtual user, bit4 = virtual supervisor.
- R6: When `virt_i` is high, privilege 0 qualifies through bit3, privilege 1 qualifies through bit4, and privilege 3 never qualifies.
- R7: A configuration write to a slot takes priority over a decrement of that slot in the same cycle. The written count is loaded unchanged.
- R8: When several slots fire at the same edge, `fire_idx_o` reports the lowest slot index.
- R9: `any_active_o` is high, combinationally, exactly when at least one slot has the instruction-count type, a nonzero count and an enable that matches the present privilege and `virt_i`.
- R10: Reset clears every slot to type 0, count 0 and no enables. It also holds `fire_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| retire_i | input | 1 | One instruction retired this cycle |
| priv_i | input | 2 | Current privilege level |
| virt_i | input | 1 | Core is running virtualised |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_sel_i | input | IDX_W (2) | Slot selected for the write |
| cfg_type_i | input | TYPE_W (4) | Type code to store |
| cfg_modes_i | input | 5 | Mode enables to store |
| cfg_count_i | input | COUNT_W (14) | Count to load |
| fire_o | output | 1 | Breakpoint request pulse |
| fire_idx_o | output | IDX_W (2) | Index of the firing slot |
| any_active_o | output | 1 | Some slot counts in the present mode |

## Verification
The assertions assume that the privilege and virtualisation inputs are stable and valid whenever `retire_i` is sampled. They also assume that a configuration write always carries a selector below the slot count. The stimulus changes every input only on the falling clock edge. It uses selectors 0 to 3 only, and it drives the reserved privilege code 2 only to show that this code never qualifies. Each stimulus cycle pushes its predicted fire and index into a queue, and a monitor compares them just after the next rising edge.

// File: rtl/icnt_pkg.sv
package icnt_pkg;
   typedef enum logic [1:0] {
      PRV_U   = 2'd0,
      PRV_S   = 2'd1,
      PRV_RSV = 2'd2,
      PRV_M   = 2'd3
   } priv_e;

   // packed: vs is bit 4, u is bit 0
   typedef struct packed {
      logic vs;
      logic vu;
      logic m;
      logic s;
      logic u;
   } mode_t;

   localparam int unsigned MODE_W = $bits(mode_t);
endpackage

// File: rtl/icnt_mode_qual.sv
module icnt_mode_qual
   import icnt_pkg::*;
#(
   parameter bit VIRT_EN = 1'b1
) (
   input  mode_t modes_i,
   input  priv_e priv_i,
   input  logic  virt_i,
   output logic  ok_o
);
   logic host_ok;

   always_comb begin
      unique case (priv_i)
         PRV_U:   host_ok = modes_i.u;
         PRV_S:   host_ok = modes_i.s;
         PRV_M:   host_ok = modes_i.m;
         default: host_ok = 1'b0;
      endcase
   end

   generate
      if (VIRT_EN) begin : g_virt
         logic guest_ok;
         always_comb begin
            unique case (priv_i)
               PRV_U:   guest_ok = modes_i.vu;
               PRV_S:   guest_ok = modes_i.vs;
               default: guest_ok = 1'b0;
            endcase
         end
         assign ok_o = virt_i ? guest_ok : host_ok;
      end else begin : g_novirt
         logic unused_virt;
         assign unused_virt = virt_i ^ modes_i.vu ^ modes_i.vs;
         assign ok_o = host_ok;
      end
   endgenerate
endmodule

// File: rtl/icnt_slot.sv
module icnt_slot
   import icnt_pkg::*;
#(
   parameter int unsigned COUNT_W     = 14,
   parameter int unsigned TYPE_W      = 4,
   parameter int unsigned ICOUNT_TYPE = 3,
   parameter bit          VIRT_EN     = 1'b1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               wr_i,
   input  logic [TYPE_W-1:0]  wr_type_i,
   input  mode_t              wr_modes_i,
   input  logic [COUNT_W-1:0] wr_count_i,
   input  logic               retire_i,
   input  priv_e              priv_i,
   input  logic               virt_i,
   output logic               armed_o,
   output logic               hit_o
);
   localparam logic [TYPE_W-1:0]  TYPE_CODE = TYPE_W'(ICOUNT_TYPE);
   localparam logic [COUNT_W-1:0] ONE       = COUNT_W'(1);

   logic [TYPE_W-1:0]  typ_q;
   mode_t              modes_q;
   logic [COUNT_W-1:0] cnt_q;
   logic               mode_ok;
   logic               qual;
   logic               step;

   icnt_mode_qual #(.VIRT_EN(VIRT_EN)) mq_i (
      .modes_i (modes_q),
      .priv_i  (priv_i),
      .virt_i  (virt_i),
      .ok_o    (mode_ok)
   );

   assign qual    = (typ_q == TYPE_CODE) && (cnt_q != '0) && mode_ok;
   assign armed_o = qual;
   assign step    = retire_i && qual && !wr_i;
   assign hit_o   = step && (cnt_q == ONE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         typ_q   <= '0;
         modes_q <= '0;
         cnt_q   <= '0;
      end else if (wr_i) begin
         typ_q   <= wr_type_i;
         modes_q <= wr_modes_i;
         cnt_q   <= wr_count_i;
      end else if (step) begin
         cnt_q   <= cnt_q - ONE;
      end
   end

   AST_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q == '0 && !wr_i) |=> (cnt_q == '0)); // R2
   AST_STEP_ONE: assert property (@(posedge clk) disable iff (!rst_n)
      (retire_i && mode_ok && typ_q == TYPE_CODE && cnt_q != '0 && !wr_i)
      |=> (cnt_q == $past(cnt_q) - ONE)); // R3
   AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && !retire_i) |=> $stable(cnt_q)); // R3
   AST_HOLD_OFFMODE: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && !mode_ok) |=> $stable(cnt_q)); // R5
   AST_FOREIGN_INERT: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_i && typ_q != TYPE_CODE) |=> $stable(cnt_q)); // R1
   AST_WR_WINS: assert property (@(posedge clk) disable iff (!rst_n)
      wr_i |=> (cnt_q == $past(wr_count_i))); // R7
endmodule

// File: rtl/icnt_prio.sv
module icnt_prio #(
   parameter int unsigned N     = 4,
   parameter int unsigned IDX_W = 2
) (
   input  logic [N-1:0]     req_i,
   output logic             any_o,
   output logic [IDX_W-1:0] idx_o
);
   always_comb begin
      idx_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req_i[i]) idx_o = IDX_W'(i);
      end
   end
   assign any_o = |req_i;
endmodule

// File: rtl/icnt_trig_unit.sv
module icnt_trig_unit
   import icnt_pkg::*;
#(
   parameter int unsigned NUM_TRIG    = 4,
   parameter int unsigned COUNT_W     = 14,
   parameter int unsigned TYPE_W      = 4,
   parameter int unsigned ICOUNT_TYPE = 3,
   parameter bit          VIRT_EN     = 1'b1,
   localparam int unsigned IDX_W      = (NUM_TRIG > 1) ? $clog2(NUM_TRIG) : 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               retire_i,
   input  logic [1:0]         priv_i,
   input  logic               virt_i,
   input  logic               cfg_we_i,
   input  logic [IDX_W-1:0]   cfg_sel_i,
   input  logic [TYPE_W-1:0]  cfg_type_i,
   input  logic [4:0]         cfg_modes_i,
   input  logic [COUNT_W-1:0] cfg_count_i,
   output logic               fire_o,
   output logic [IDX_W-1:0]   fire_idx_o,
   output logic               any_active_o
);
   generate
      if (NUM_TRIG < 1) begin : g_bad_n
         $error("NUM_TRIG must be at least 1");
      end
      if (COUNT_W < 2) begin : g_bad_w
         $error("COUNT_W must be at least 2");
      end
      if (ICOUNT_TYPE >= (1 << TYPE_W)) begin : g_bad_t
         $error("ICOUNT_TYPE does not fit TYPE_W");
      end
   endgenerate

   logic [NUM_TRIG-1:0] armed;
   logic [NUM_TRIG-1:0] hit;
   logic                hit_any;
   logic [IDX_W-1:0]    hit_idx;
   logic                fire_q;
   logic [IDX_W-1:0]    idx_q;
   priv_e               priv;
   mode_t               wr_modes;

   assign priv     = priv_e'(priv_i);
   assign wr_modes = mode_t'(cfg_modes_i);

   generate
      for (genvar g = 0; g < NUM_TRIG; g++) begin : g_slot
         icnt_slot #(
            .COUNT_W     (COUNT_W),
            .TYPE_W      (TYPE_W),
            .ICOUNT_TYPE (ICOUNT_TYPE),
            .VIRT_EN     (VIRT_EN)
         ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .wr_i       (cfg_we_i && (cfg_sel_i == IDX_W'(g))),
            .wr_type_i  (cfg_type_i),
            .wr_modes_i (wr_modes),
            .wr_count_i (cfg_count_i),
            .retire_i   (retire_i),
            .priv_i     (priv),
            .virt_i     (virt_i),
            .armed_o    (armed[g]),
            .hit_o      (hit[g])
         );
      end
   endgenerate

   icnt_prio #(.N(NUM_TRIG), .IDX_W(IDX_W)) prio_i (
      .req_i (hit),
      .any_o (hit_any),
      .idx_o (hit_idx)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fire_q <= 1'b0;
         idx_q  <= '0;
      end else begin
         fire_q <= hit_any;
         idx_q  <= hit_idx;
      end
   end

   assign fire_o       = fire_q;
   assign fire_idx_o   = idx_q;
   assign any_active_o = |armed;

   AST_FIRE_NEEDS_RETIRE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> $past(retire_i)); // R4
   AST_HIT_ONEHOT_IDX: assert property (@(posedge clk) disable iff (!rst_n)
      hit_any |=> (fire_o && fire_idx_o == $past(hit_idx))); // R8
   AST_FIRE_IDX_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      fire_o |-> (32'(fire_idx_o) < NUM_TRIG)); // R8
   AST_NO_FIRE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !retire_i |=> !fire_o); // R3
endmodule

// File: tb/icnt_trig_unit_tb.sv
module icnt_trig_unit_tb_top;
   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        retire_i = 1'b0;
   logic [1:0]  priv_i = 2'd3;
   logic        virt_i = 1'b0;
   logic        cfg_we_i = 1'b0;
   logic [1:0]  cfg_sel_i = '0;
   logic [3:0]  cfg_type_i = '0;
   logic [4:0]  cfg_modes_i = '0;
   logic [13:0] cfg_count_i = '0;
   logic        fire_o;
   logic [1:0]  fire_idx_o;
   logic        any_active_o;

   always #5 clk = ~clk;

   icnt_trig_unit dut_i (
      .clk(clk), .rst_n(rst_n), .retire_i(retire_i), .priv_i(priv_i),
      .virt_i(virt_i), .cfg_we_i(cfg_we_i), .cfg_sel_i(cfg_sel_i),
      .cfg_type_i(cfg_type_i), .cfg_modes_i(cfg_modes_i),
      .cfg_count_i(cfg_count_i), .fire_o(fire_o), .fire_idx_o(fire_idx_o),
      .any_active_o(any_active_o)
   );

   typedef struct {
      logic  fire;
      int    idx;
      string tag;
   } exp_t;

   exp_t        sb_q[$];
   int          n_chk = 0;
   int          n_bad = 0;
   bit          done = 0;
   logic [3:0]  m_typ [N];
   logic [4:0]  m_mod [N];
   int          m_cnt [N];

   function automatic bit mode_ok(logic [4:0] m, logic [1:0] p, logic v);
      if (v) return (p == 2'd0) ? m[3] : (p == 2'd1) ? m[4] : 1'b0;
      case (p)
         2'd0: return m[0];
         2'd1: return m[1];
         2'd3: return m[2];
         default: return 1'b0;
      endcase
   endfunction

   function automatic bit qual(int i, logic [1:0] p, logic v);
      return m_typ[i] == 4'd3 && m_cnt[i] != 0 && mode_ok(m_mod[i], p, v);
   endfunction

   task automatic check(bit ok, string tag, int act, int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
      end
   endtask

   // one stimulus cycle: drive, check status, predict next-edge result
   task automatic step(bit we, int sel, int typ, int modes, int cnt,
                       bit ret, int p, bit v, string tag);
      exp_t e;
      bit   act_exp;
      @(negedge clk);
      cfg_we_i = we; cfg_sel_i = 2'(sel); cfg_type_i = 4'(typ);
      cfg_modes_i = 5'(modes); cfg_count_i = 14'(cnt);
      retire_i = ret; priv_i = 2'(p); virt_i = v;
      #1;
      act_exp = 0;
      for (int i = 0; i < N; i++) if (qual(i, 2'(p), v)) act_exp = 1;
      check(any_active_o == act_exp, {"R9 any_active ", tag}, any_active_o, act_exp);
      e.fire = 0; e.idx = 0; e.tag = tag;
      for (int i = N - 1; i >= 0; i--) begin
         if (we && sel == i) begin
            m_typ[i] = 4'(typ); m_mod[i] = 5'(modes); m_cnt[i] = cnt;
         end else if (ret && qual(i, 2'(p), v)) begin
            m_cnt[i]--;
            if (m_cnt[i] == 0) begin e.fire = 1; e.idx = i; end
         end
      end
      sb_q.push_back(e);
   endtask

   task automatic cfg(int sel, int typ, int modes, int cnt, string tag);
      step(1, sel, typ, modes, cnt, 0, 3, 0, tag);
   endtask

   task automatic ret(int p, bit v, int n, string tag);
      for (int k = 0; k < n; k++) step(0, 0, 0, 0, 0, 1, p, v, tag);
   endtask

   always @(posedge clk) begin
      #1;
      if (sb_q.size() > 0) begin
         exp_t e;
         e = sb_q.pop_front();
         check(fire_o == e.fire, {"fire ", e.tag}, fire_o, e.fire);
         if (e.fire) check(int'(fire_idx_o) == e.idx, {"R8 idx ", e.tag},
                           fire_idx_o, e.idx);
      end
   end

   task automatic summary();
      $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         n_chk++; n_bad++;
         $display("FAIL watchdog actual=1 expected=0");
         summary();
      end
   end

   initial begin
      for (int i = 0; i < N; i++) begin m_typ[i] = 0; m_mod[i] = 0; m_cnt[i] = 0; end
      repeat (3) @(posedge clk);
      #1;
      check(fire_o == 0, "R10 reset fire", fire_o, 0);
      check(any_active_o == 0, "R10 reset any_active", any_active_o, 0);
      @(negedge clk); rst_n = 1'b1;
      ret(3, 0, 2, "R10 cleared slots never fire");
      // R3 R4: count 3 in machine mode fires on third retire
      cfg(0, 3, 5'b00100, 3, "R4 load");
      ret(3, 0, 3, "R3 R4 countdown");
      ret(3, 0, 3, "R2 idle after fire");
      // R3: no retire, no decrement
      cfg(0, 3, 5'b00100, 2, "R3 reload");
      step(0, 0, 0, 0, 0, 0, 3, 0, "R3 no retire");
      step(0, 0, 0, 0, 0, 0, 3, 0, "R3 no retire");
      ret(3, 0, 2, "R3 resumes");
      // R5: user-only slot ignores supervisor and machine
      cfg(1, 3, 5'b00001, 2, "R5 load");
      ret(1, 0, 3, "R5 supervisor ignored");
      ret(3, 0, 2, "R5 machine ignored");
      ret(2, 0, 2, "R5 reserved priv");
      ret(0, 0, 2, "R5 user counts");
      // R6: virtual supervisor only
      cfg(2, 3, 5'b10000, 1, "R6 load");
      ret(1, 0, 2, "R6 host supervisor ignored");
      ret(3, 1, 2, "R6 machine under virt ignored");
      ret(1, 1, 1, "R6 virtual supervisor fires");
      cfg(2, 3, 5'b01100, 2, "R6 load vu");
      ret(0, 0, 1, "R6 host user ignored");
      ret(0, 1, 2, "R6 virtual user fires");
      // R1: foreign type inert, all modes enabled
      cfg(3, 2, 5'b11111, 1, "R1 foreign");
      ret(3, 0, 2, "R1 foreign inert");
      ret(0, 1, 1, "R1 foreign inert virt");
      // R2: zero count with icount type is inert
      cfg(3, 3, 5'b11111, 0, "R2 zero load");
      ret(3, 0, 2, "R2 zero inert");
      // R7: write beats decrement in the same cycle
      cfg(0, 3, 5'b00100, 5, "R7 preload");
      ret(3, 0, 1, "R7 step");
      step(1, 0, 3, 5'b00100, 1, 1, 3, 0, "R7 write with retire");
      ret(3, 0, 1, "R7 fires from written count");
      // R8: simultaneous fire reports lowest index
      cfg(1, 3, 5'b00100, 1, "R8 load1");
      cfg(3, 3, 5'b00100, 1, "R8 load3");
      ret(3, 0, 1, "R8 tie 1 vs 3");
      cfg(0, 3, 5'b00100, 2, "R8 load0");
      cfg(2, 3, 5'b00100, 2, "R8 load2");
      ret(3, 0, 2, "R8 tie 0 vs 2");
      // R4: a long count
      cfg(2, 3, 5'b00010, 40, "R4 long");
      ret(1, 0, 41, "R4 long countdown");
      step(0, 0, 0, 0, 0, 0, 3, 0, "drain");
      step(0, 0, 0, 0, 0, 0, 3, 0, "drain");
      wait (sb_q.size() == 0);
      @(negedge clk);
      done = 1;
      summary();
   end
endmodule